// File: doc/BRIEF.md
# Staggered-Schedule Shift-Register LDPC Decoder Core

This core decodes one block of a quasi-cyclic low-density parity-check code. The block has 4·P bits, and the code has P parity checks whose rows are cyclic shifts of one another. The core keeps one saturated soft value per bit. It does not keep one value per graph edge. Checks are visited one per clock in a staggered order. On each visit, the soft values of the four bits the check touches are sent to a pipelined min-sum check-node unit, and the four returned messages are added back into those same bits. The bit's own earlier contribution is not removed first.

The bits sit in four parallel circular shift-register chains, one per column-split group, with P stages each. Every chain rotates one stage per decoding step. Because of this, a fixed read tap in each chain always sees the bit that the current check needs, and a fixed write position receives that bit's update after the three-cycle check-node latency. The user streams channel LLRs in four per beat, pulses start with an iteration count, waits for the done pulse and then reads the hard decisions.

Top module: `lsr_decoder`

## Requirements
- R1: While reset is applied and just after it, busy and done are 0 and every hard decision is 0.
- R2: In idle, each cycle with load_valid high and start low accepts one beat, which shifts into all four chains. The last P beats accepted form the block: beat i of those P supplies bit 4·i+c from load_llr[c·W +: W] (two's complement), for c = 0..3. An input of −2^(W−1) is stored as −(2^(W−1)−1).
- R3: While busy, load beats and start pulses are ignored. Stored values, the run length and the result are unaffected.
- R4: iter_sel in 1..7 selects that many iterations, and 0 selects 3. One iteration visits all P checks once.
- R5: Decoding step s activates check m = s mod P, and steps run in increasing order. Check m joins, on each chain c, the bit at position (m + TAP_OFF[c]) mod P, which is block bit 4·((m + TAP_OFF[c]) mod P) + c.
- R6: The message returned to each joined bit is the min-sum rule over the other three. Its sign is negative when an odd number of the other three values are negative (a value of zero counts as non-negative). Its magnitude is the smallest magnitude among the other three.
- R7: Each joined bit adds its message to its running value, saturated to ±(2^(W−1)−1), with no subtraction of earlier messages. Running values persist, so a start with no new load continues from them.
- R8: After start is sampled in idle, busy stays high and done rises exactly iters·P + P cycles later, as a one-cycle pulse, with busy then low.
- R9: hard_o[4·j+c] is 1 exactly when the running value of that bit is greater than 0. In idle with no load, hard_o holds steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_valid | input | 1 | LLR beat present |
| load_llr | input | 4·W | Four LLRs, chain c in slice c·W |
| start | input | 1 | Begin decoding (idle only) |
| iter_sel | input | 3 | Iteration count, 0 means 3 |
| busy | output | 1 | Decoding in progress |
| done | output | 1 | One-cycle end-of-decode pulse |
| hard_o | output | 4·P | Hard decisions, bit 4·j+c |

## Verification
A load beat takes effect at the clock edge that samples it. The done pulse is due iters·P + P edges after the edge that samples start. The bench therefore counts falling edges from the start sample and requires done to appear on exactly that count, with busy high on every earlier count. The bench drives inputs and reads outputs only on falling clock edges. Hard decisions are compared with a sequential bench model in the same falling-edge window that done first shows high. They are compared again several idle cycles later. The stray beats and start pulses in the ignore test are placed in the middle of a run, so a wrongly accepted pulse would shift both the done count and the decisions.

// File: rtl/lsr_pkg.sv
package lsr_pkg;
  localparam int NCH      = 4;   // parallel chains after column splitting
  localparam int LAT      = 3;   // check-node pipeline depth
  localparam int MAX_ITER = 7;
  localparam int DEF_ITER = 3;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2
  } lsr_state_e;

  // symmetric saturation to +/-(2^(w-1)-1)
  function automatic int clamp_sym(input int v, input int w);
    int lim;
    lim = (1 << (w - 1)) - 1;
    if (v > lim) return lim;
    if (v < -lim) return -lim;
    return v;
  endfunction

  function automatic int eff_iter(input int sel);
    return (sel == 0) ? DEF_ITER : sel;
  endfunction
endpackage

// File: rtl/lsr_chain.sv
module lsr_chain
  import lsr_pkg::*;
#(
  parameter int P   = 7,
  parameter int W   = 8,
  parameter int OFF = 0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_en,
  input  logic signed [W-1:0] load_val,
  input  logic                rot_en,
  input  logic                wr_en,
  input  logic signed [W-1:0] wr_msg,
  output logic signed [W-1:0] tap_o,
  output logic [P*W-1:0]      vals_o
);
  // position holding the bit LAT rotations after it was read, and
  // where its updated value lands after this edge's rotation
  localparam int RPOS = (((OFF - LAT) % P) + P) % P;
  localparam int WPOS = (RPOS + P - 1) % P;

  logic signed [W-1:0] q  [P];
  logic signed [W-1:0] nq [P];

  function automatic logic signed [W-1:0] fit(input int v);
    return W'(clamp_sym(v, W));
  endfunction

  always_comb begin
    for (int r = 0; r < P; r++) begin
      if (load_en)
        nq[r] = (r == P - 1) ? fit(int'(load_val)) : q[(r + 1) % P];
      else if (rot_en)
        nq[r] = q[(r + 1) % P];
      else
        nq[r] = q[r];
    end
    if (!load_en && rot_en && wr_en)
      nq[WPOS] = fit(int'(q[RPOS]) + int'(wr_msg));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < P; r++) q[r] <= '0;
    end else begin
      for (int r = 0; r < P; r++) q[r] <= nq[r];
    end
  end

  assign tap_o = q[OFF];

  for (genvar r = 0; r < P; r++) begin : g_flat
    assign vals_o[r*W +: W] = q[r];
    // R7: saturation never reaches the asymmetric most-negative code
    p_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
      q[r] != {1'b1, {(W-1){1'b0}}});
  end

  // R9: with neither loading nor rotating the stored values do not move
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && !rot_en) |=> $stable(vals_o));
endmodule

// File: rtl/lsr_cnu.sv
module lsr_cnu
  import lsr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [NCH*W-1:0] in_v,
  output logic             out_valid,
  output logic [NCH*W-1:0] out_m
);
  localparam int MW = W - 1;
  localparam int IW = $clog2(NCH);

  function automatic logic [MW-1:0] mag_of(input logic signed [W-1:0] v);
    return (v < 0) ? MW'(-v) : MW'(v);
  endfunction

  function automatic logic signed [W-1:0] with_sign(input logic neg, input logic [MW-1:0] m);
    logic signed [W-1:0] x;
    x = $signed({1'b0, m});
    return neg ? -x : x;
  endfunction

  // stage 1: capture taps
  logic                s1_vld;
  logic signed [W-1:0] s1 [NCH];
  // stage 2: signs, two smallest magnitudes
  logic                s2_vld, s2_par;
  logic [NCH-1:0]      s2_neg;
  logic [MW-1:0]       s2_min1, s2_min2;
  logic [IW-1:0]       s2_idx;
  // stage 3: messages
  logic signed [W-1:0] s3 [NCH];

  logic [NCH-1:0] c_neg;
  logic           c_par;
  logic [MW-1:0]  c_min1, c_min2, c_mag;
  logic [IW-1:0]  c_idx;

  always_comb begin
    c_min1 = '1;
    c_min2 = '1;
    c_idx  = '0;
    c_par  = 1'b0;
    c_mag  = '0;
    for (int c = 0; c < NCH; c++) begin
      c_neg[c] = s1[c] < 0;
      c_par    = c_par ^ c_neg[c];
      c_mag    = mag_of(s1[c]);
      if (c_mag < c_min1) begin
        c_min2 = c_min1;
        c_min1 = c_mag;
        c_idx  = IW'(c);
      end else if (c_mag < c_min2) begin
        c_min2 = c_mag;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_vld <= 1'b0; s2_vld <= 1'b0; out_valid <= 1'b0;
      s2_par <= 1'b0; s2_neg <= '0; s2_min1 <= '0; s2_min2 <= '0; s2_idx <= '0;
      for (int c = 0; c < NCH; c++) begin
        s1[c] <= '0;
        s3[c] <= '0;
      end
    end else begin
      s1_vld <= in_valid;
      for (int c = 0; c < NCH; c++) s1[c] <= $signed(in_v[c*W +: W]);
      s2_vld  <= s1_vld;
      s2_par  <= c_par;
      s2_neg  <= c_neg;
      s2_min1 <= c_min1;
      s2_min2 <= c_min2;
      s2_idx  <= c_idx;
      out_valid <= s2_vld;
      for (int c = 0; c < NCH; c++)
        s3[c] <= with_sign(s2_par ^ s2_neg[c], (IW'(c) == s2_idx) ? s2_min2 : s2_min1);
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_out
    assign out_m[c*W +: W] = s3[c];
    // R6: a message magnitude comes from a stored value, so it stays symmetric
    p_msg_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (s3[c] != {1'b1, {(W-1){1'b0}}}));
  end

  // R5: every issued check returns exactly LAT cycles later
  p_lat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##3 out_valid);
endmodule

// File: rtl/lsr_ctrl.sv
module lsr_ctrl
  import lsr_pkg::*;
#(
  parameter int P = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [2:0] iter_sel,
  output logic       busy,
  output logic       done,
  output logic       issue
);
  localparam int SW = $clog2(MAX_ITER * P + 1);
  localparam int DW = $clog2(P + 1);

  lsr_state_e    state;
  logic [SW-1:0] step_cnt, last_step;
  logic [DW-1:0] drain_cnt;
  logic          done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      step_cnt  <= '0;
      last_step <= '0;
      drain_cnt <= '0;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          last_step <= SW'(eff_iter(int'(iter_sel)) * P - 1);
          step_cnt  <= '0;
          state     <= ST_RUN;
        end
        ST_RUN: if (step_cnt == last_step) begin
          drain_cnt <= '0;
          state     <= ST_DRAIN;
        end else begin
          step_cnt <= step_cnt + 1'b1;
        end
        ST_DRAIN: if (drain_cnt == DW'(P - 1)) begin
          state  <= ST_IDLE;
          done_q <= 1'b1;
        end else begin
          drain_cnt <= drain_cnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy  = (state != ST_IDLE);
  assign issue = (state == ST_RUN);
  assign done  = done_q;

  // R8: done is a single-cycle pulse
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8: busy only ends together with the done pulse
  p_busy_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
endmodule

// File: rtl/lsr_decoder.sv
module lsr_decoder
  import lsr_pkg::*;
#(
  parameter int P = 7,
  parameter int W = 8,
  parameter int TAP_OFF [NCH] = '{0, 1, 3, 5}
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_valid,
  input  logic [NCH*W-1:0] load_llr,
  input  logic             start,
  input  logic [2:0]       iter_sel,
  output logic             busy,
  output logic             done,
  output logic [NCH*P-1:0] hard_o
);
  logic             busy_w, issue, load_en, msg_vld;
  logic [NCH*W-1:0] tap_bus, msg_bus;
  logic [P*W-1:0]   vals [NCH];

  assign load_en = load_valid && !busy_w && !start;

  lsr_ctrl #(.P(P)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .iter_sel(iter_sel),
    .busy(busy_w), .done(done), .issue(issue)
  );

  lsr_cnu #(.W(W)) u_cnu (
    .clk(clk), .rst_n(rst_n), .in_valid(issue), .in_v(tap_bus),
    .out_valid(msg_vld), .out_m(msg_bus)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chain
    lsr_chain #(.P(P), .W(W), .OFF(TAP_OFF[c])) u_chain (
      .clk(clk), .rst_n(rst_n),
      .load_en(load_en), .load_val(load_llr[c*W +: W]),
      .rot_en(busy_w), .wr_en(msg_vld), .wr_msg(msg_bus[c*W +: W]),
      .tap_o(tap_bus[c*W +: W]), .vals_o(vals[c])
    );
    for (genvar j = 0; j < P; j++) begin : g_hard
      assign hard_o[j*NCH + c] = ($signed(vals[c][j*W +: W]) > 0);
    end
  end

  assign busy = busy_w;

  // R5: check-node results only come back while the chains are rotating
  p_wb_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    msg_vld |-> busy_w);
endmodule

// File: tb/tb_lsr_decoder.sv
module tb_lsr_decoder;
  import lsr_pkg::*;
  localparam int P   = 7;
  localparam int W   = 8;
  localparam int LIM = (1 << (W - 1)) - 1;
  localparam int OFF [NCH] = '{0, 1, 3, 5};

  logic             clk = 1'b0, rst_n = 1'b0, load_valid = 1'b0, start = 1'b0;
  logic [NCH*W-1:0] load_llr = '0;
  logic [2:0]       iter_sel = '0;
  logic             busy, done;
  logic [NCH*P-1:0] hard_o;

  always #2.5 clk = ~clk;

  lsr_decoder #(.P(P), .W(W), .TAP_OFF(OFF)) dut (
    .clk(clk), .rst_n(rst_n), .load_valid(load_valid), .load_llr(load_llr),
    .start(start), .iter_sel(iter_sel), .busy(busy), .done(done), .hard_o(hard_o)
  );

  int checks = 0, fails = 0;
  int blk [NCH][P];
  int mq  [NCH][P];

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic int sat(input int v);
    return (v > LIM) ? LIM : ((v < -LIM) ? -LIM : v);
  endfunction

  function automatic logic [NCH*P-1:0] exp_hard();
    logic [NCH*P-1:0] r;
    for (int j = 0; j < P; j++)
      for (int c = 0; c < NCH; c++) r[j*NCH + c] = (mq[c][j] > 0);
    return r;
  endfunction

  // sequential staggered schedule, one check at a time
  task automatic model_run(input int iters);
    int v [NCH];
    int msg [NCH];
    for (int s = 0; s < iters * P; s++) begin
      int m = s % P;
      for (int c = 0; c < NCH; c++) v[c] = mq[c][(m + OFF[c]) % P];
      for (int c = 0; c < NCH; c++) begin
        int negs = 0, mn = 1 << 30;
        for (int d = 0; d < NCH; d++) if (d != c) begin
          if (v[d] < 0) negs++;
          if ((v[d] < 0 ? -v[d] : v[d]) < mn) mn = (v[d] < 0 ? -v[d] : v[d]);
        end
        msg[c] = (negs % 2 == 1) ? -mn : mn;
      end
      for (int c = 0; c < NCH; c++)
        mq[c][(m + OFF[c]) % P] = sat(v[c] + msg[c]);
    end
  endtask

  task automatic load_blk();
    for (int j = 0; j < P; j++) begin
      for (int c = 0; c < NCH; c++) begin
        load_llr[c*W +: W] = W'(blk[c][j]);
        mq[c][j] = sat(blk[c][j]);
      end
      load_valid = 1'b1;
      @(negedge clk);
    end
    load_valid = 1'b0;
  endtask

  task automatic decode(input int sel, input bit poke, input string tag);
    int iters = (sel == 0) ? 3 : sel;
    int want  = iters * P + P;
    int cyc   = 0;
    bit busy_ok = 1'b1;
    iter_sel = 3'(sel);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && cyc < 1000) begin
      if (!busy) busy_ok = 1'b0;
      if (poke && cyc == 2) begin
        load_valid = 1'b1; load_llr = '1; start = 1'b1;
      end else if (poke && cyc == 3) begin
        load_valid = 1'b0; start = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    model_run(iters);
    chk(cyc == want, {tag, " R8 R4 done cycle"}, cyc, want);
    chk(busy_ok, {tag, " R8 busy during run"}, busy_ok, 1);
    chk(!busy, {tag, " R8 busy low at done"}, busy, 0);
    chk(hard_o == exp_hard(), {tag, " R5 R6 R7 R9 hard decisions"}, hard_o, exp_hard());
    @(negedge clk);
    chk(!done, {tag, " R8 done one cycle"}, done, 0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(!busy && !done, "R1 flags in reset", {busy, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done, "R1 flags after reset", {busy, done}, 0);
    chk(hard_o == '0, "R1 hard after reset", hard_o, 0);
  endtask

  task automatic t_strong();
    for (int c = 0; c < NCH; c++) for (int j = 0; j < P; j++) blk[c][j] = 40;
    load_blk();
    decode(1, 1'b0, "strong R2");
  endtask

  task automatic t_mixed_default();
    for (int c = 0; c < NCH; c++) for (int j = 0; j < P; j++)
      blk[c][j] = ((c * 7 + j * 13) % 41) - 20;
    load_blk();
    decode(0, 1'b0, "mixed R4 default");
  endtask

  task automatic t_weak_error();
    for (int c = 0; c < NCH; c++) for (int j = 0; j < P; j++) blk[c][j] = 30;
    blk[1][2] = -5;
    load_blk();
    decode(2, 1'b0, "weak error R6");
    chk(hard_o[2*NCH + 1] == 1'b1, "R6 R7 weak bit corrected", hard_o[2*NCH + 1], 1);
  endtask

  task automatic t_extreme();
    for (int c = 0; c < NCH; c++) for (int j = 0; j < P; j++)
      blk[c][j] = ((c + j) % 2 == 1) ? -128 : 127;
    load_blk();
    decode(7, 1'b0, "extreme R2 clamp R7 saturate");
  endtask

  task automatic t_continue();
    decode(1, 1'b0, "continue R7 no reload");
  endtask

  task automatic t_busy_ignore();
    for (int c = 0; c < NCH; c++) for (int j = 0; j < P; j++)
      blk[c][j] = ((c * 5 + j * 3) % 17) - 6;
    load_blk();
    decode(3, 1'b1, "ignore R3");
  endtask

  task automatic t_extra_beats();
    for (int k = 0; k < 3; k++) begin
      load_llr = '1;
      load_valid = 1'b1;
      @(negedge clk);
    end
    load_valid = 1'b0;
    for (int c = 0; c < NCH; c++) for (int j = 0; j < P; j++)
      blk[c][j] = ((c * 11 + j * 5) % 23) - 9;
    load_blk();
    decode(2, 1'b0, "extra beats R2");
  endtask

  task automatic t_hold();
    logic [NCH*P-1:0] snap = exp_hard();
    repeat (6) @(negedge clk);
    chk(hard_o == snap, "R9 held in idle", hard_o, snap);
    chk(!busy && !done, "R9 idle flags", {busy, done}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_strong();
    t_mixed_default();
    t_weak_error();
    t_extreme();
    t_continue();
    t_busy_ignore();
    t_extra_beats();
    t_hold();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule